// File: doc/BRIEF.md
# Link Idle Power-State Entry Controller

This block watches the transmit and receive activity of a serial link and decides when the link should drop into a low-power state. There are two such states. The light state idles a single direction and can be requested for transmit and receive separately. The deep state idles both directions at once. It saves more power, but leaving it takes longer. Three idle counters drive the decision. Each direction has its own counter, and a third counter runs only while both directions are quiet. Each state has its own programmable 16-bit set point.

A two-bit enable field and a flag that reports whether the far end supports the light state gate both requests. A set point of zero turns its state off. The deep state always wins: raising it withdraws any light-state request. If the light set point is not below the deep set point, the link goes straight to the deep state. Traffic that appears on a sleeping direction raises a wake request. That request is held until the physical layer acknowledges it. The link is then active again, and every idle count starts over.

All pins are plain control and status levels. No data passes through the block, so it has no valid/ready interface and no back-pressure.

Top module: `link_idle_pm_ctrl`

## Requirements
- R1: When a direction's activity input has been low for `l0s_idle_limit` consecutive sampled cycles, that direction's light-sleep request goes high on the next cycle. The transmit and receive directions are judged independently.
- R2: When both directions have been idle for `l1_idle_limit` consecutive sampled cycles, `l1_req` goes high on the next cycle.
- R3: `l1_req` and either light-sleep request are never high together. In the cycle where `l1_req` rises, any light-sleep request falls.
- R4: While the deep state is usable, a light set point equal to or above the deep set point means no light-sleep request is ever raised.
- R5: While `far_l0s_capable` is low, no light-sleep request is raised. A request that is already high falls on the next cycle.
- R6: `pm_enable` bit 0 permits the light state and bit 1 permits the deep state. The encodings are 00 = none, 01 = light only, 10 = deep only, 11 = both. A request whose state has been disabled falls on the next cycle.
- R7: A set point of zero disables its state.
- R8: Activity on a direction in light sleep, or on either direction while in the deep state, raises `wake_req` on the next cycle. The current sleep requests stay high.
- R9: `wake_req` stays high until `wake_ack` is sampled high. On the cycle after that, `wake_req` and all sleep requests are low, and every idle count restarts from zero.
- R10: After reset, every output is low.
- R11: Any activity on a direction clears that direction's idle count, so a new entry needs the full set point again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Transmit traffic present this cycle |
| rx_active | input | 1 | Receive traffic present this cycle |
| pm_enable | input | 2 | Bit 0 permits light sleep, bit 1 permits deep sleep |
| far_l0s_capable | input | 1 | The far end supports light sleep |
| l0s_idle_limit | input | 16 | Light-sleep idle set point in cycles, 0 = off |
| l1_idle_limit | input | 16 | Deep-sleep idle set point in cycles, 0 = off |
| wake_ack | input | 1 | The physical layer has finished waking the link |
| tx_l0s_req | output | 1 | Request light sleep for the transmit direction |
| rx_l0s_req | output | 1 | Request light sleep for the receive direction |
| l1_req | output | 1 | Request deep sleep for both directions |
| wake_req | output | 1 | Request that the link return to the active state |

## Verification
The bench builds the block with its default 16-bit count width. It drives small set points, from 3 to 10 cycles, so every entry, override and wake sequence is reached within a few dozen cycles. The set points are chosen to cover several orderings: light below deep, light equal to deep, and each of them zero. These orderings exercise the deep-over-light priority and both disable paths. The partner flag and the enable field are also changed while a request is already high, to check that the request is withdrawn.

// File: rtl/link_pm_pkg.sv
package link_pm_pkg;
  localparam int unsigned EN_LIGHT_BIT = 0;
  localparam int unsigned EN_DEEP_BIT  = 1;
  localparam int unsigned NUM_DIR      = 2;
  localparam int unsigned DIR_TX       = 0;
  localparam int unsigned DIR_RX       = 1;

  typedef struct packed {
    logic light_ok;
    logic deep_ok;
  } pm_allow_t;
endpackage

// File: rtl/pm_idle_counter.sv
module pm_idle_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // The count saturates at its maximum, so a long idle stretch never wraps.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (clear || active)  count <= '0;
    else if (count != CNT_MAX) count <= count + 1'b1;
  end

  // R11
  a_r11_activity_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (count == '0));
endmodule

// File: rtl/pm_policy.sv
module pm_policy
  import link_pm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [1:0]       pm_enable,
  input  logic             far_l0s_capable,
  input  logic [CNT_W-1:0] light_limit,
  input  logic [CNT_W-1:0] deep_limit,
  output pm_allow_t        allow
);
  logic deep_usable;
  logic light_before_deep;

  always_comb begin
    deep_usable       = pm_enable[EN_DEEP_BIT] && (deep_limit != '0);
    light_before_deep = !deep_usable || (light_limit < deep_limit);
    allow.deep_ok     = deep_usable;
    allow.light_ok    = pm_enable[EN_LIGHT_BIT] && far_l0s_capable
                        && (light_limit != '0) && light_before_deep;
  end
endmodule

// File: rtl/pm_state.sv
module pm_state
  import link_pm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pm_allow_t          allow,
  input  logic [NUM_DIR-1:0] dir_act,
  input  logic [CNT_W-1:0]   tx_count,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   both_count,
  input  logic [CNT_W-1:0]   light_limit,
  input  logic [CNT_W-1:0]   deep_limit,
  input  logic               wake_ack,
  output logic [NUM_DIR-1:0] light_q,
  output logic               deep_q,
  output logic               wake_q,
  output logic               count_clear
);
  logic [NUM_DIR-1:0] light_hit, light_n;
  logic               deep_hit, deep_n, wake_n, wake_hit;

  always_comb begin
    light_hit[DIR_TX] = allow.light_ok && (tx_count >= light_limit);
    light_hit[DIR_RX] = allow.light_ok && (rx_count >= light_limit);
    deep_hit          = allow.deep_ok && (both_count >= deep_limit);
    wake_hit          = (|(light_q & dir_act)) || (deep_q && (|dir_act));
    count_clear       = wake_q && wake_ack;

    // A request whose state is no longer permitted falls in every branch.
    light_n = light_q & {NUM_DIR{allow.light_ok}};
    deep_n  = deep_q && allow.deep_ok;
    wake_n  = wake_q;

    if (wake_q) begin
      if (wake_ack) begin
        light_n = '0;
        deep_n  = 1'b0;
        wake_n  = 1'b0;
      end
    end else if (wake_hit) begin
      wake_n = 1'b1;
    end else begin
      deep_n  = deep_n || deep_hit;
      light_n = (light_n | light_hit) & {NUM_DIR{!deep_n}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      light_q <= '0;
      deep_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      light_q <= light_n;
      deep_q  <= deep_n;
      wake_q  <= wake_n;
    end
  end

  // R3
  a_r3_deep_excludes_light: assert property (@(posedge clk) disable iff (!rst_n)
    deep_q |-> (light_q == '0));
  // R9
  a_r9_wake_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && !wake_ack) |=> wake_q);
  // R9
  a_r9_ack_returns_active: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && wake_ack) |=> (!wake_q && !deep_q && (light_q == '0)));
endmodule

// File: rtl/link_idle_pm_ctrl.sv
module link_idle_pm_ctrl
  import link_pm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_active,
  input  logic             rx_active,
  input  logic [1:0]       pm_enable,
  input  logic             far_l0s_capable,
  input  logic [CNT_W-1:0] l0s_idle_limit,
  input  logic [CNT_W-1:0] l1_idle_limit,
  input  logic             wake_ack,
  output logic             tx_l0s_req,
  output logic             rx_l0s_req,
  output logic             l1_req,
  output logic             wake_req
);
  logic [NUM_DIR-1:0] dir_act;
  logic [CNT_W-1:0]   dir_count [NUM_DIR];
  logic [CNT_W-1:0]   both_count;
  logic [NUM_DIR-1:0] light_q;
  logic               count_clear;
  pm_allow_t          allow;

  assign dir_act[DIR_TX] = tx_active;
  assign dir_act[DIR_RX] = rx_active;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    pm_idle_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (count_clear),
      .active (dir_act[d]),
      .count  (dir_count[d])
    );
  end

  pm_idle_counter #(.CNT_W(CNT_W)) u_both_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (count_clear),
    .active (|dir_act),
    .count  (both_count)
  );

  pm_policy #(.CNT_W(CNT_W)) u_policy (
    .pm_enable       (pm_enable),
    .far_l0s_capable (far_l0s_capable),
    .light_limit     (l0s_idle_limit),
    .deep_limit      (l1_idle_limit),
    .allow           (allow)
  );

  pm_state #(.CNT_W(CNT_W)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .allow       (allow),
    .dir_act     (dir_act),
    .tx_count    (dir_count[DIR_TX]),
    .rx_count    (dir_count[DIR_RX]),
    .both_count  (both_count),
    .light_limit (l0s_idle_limit),
    .deep_limit  (l1_idle_limit),
    .wake_ack    (wake_ack),
    .light_q     (light_q),
    .deep_q      (l1_req),
    .wake_q      (wake_req),
    .count_clear (count_clear)
  );

  assign tx_l0s_req = light_q[DIR_TX];
  assign rx_l0s_req = light_q[DIR_RX];

  // R5
  a_r5_no_light_without_partner: assert property (@(posedge clk) disable iff (!rst_n)
    !far_l0s_capable |=> (!tx_l0s_req && !rx_l0s_req));
  // R6
  a_r6_deep_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_enable[EN_DEEP_BIT] |=> !l1_req);
  // R7
  a_r7_zero_limit_off: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_idle_limit == '0) |=> !l1_req);
  // R8
  a_r8_tx_traffic_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_l0s_req && tx_active) |=> wake_req);
endmodule

// File: tb/test_link_idle_pm_ctrl.sv
module test_link_idle_pm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_active = 1'b0, rx_active = 1'b0;
  logic [1:0]  pm_enable = 2'b00;
  logic        far_l0s_capable = 1'b0;
  logic [15:0] l0s_idle_limit = '0, l1_idle_limit = '0;
  logic        wake_ack = 1'b0;
  logic        tx_l0s_req, rx_l0s_req, l1_req, wake_req;
  int          n_checks = 0, n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  link_idle_pm_ctrl i_link_idle_pm_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_active(rx_active),
    .pm_enable(pm_enable), .far_l0s_capable(far_l0s_capable),
    .l0s_idle_limit(l0s_idle_limit), .l1_idle_limit(l1_idle_limit),
    .wake_ack(wake_ack), .tx_l0s_req(tx_l0s_req), .rx_l0s_req(rx_l0s_req),
    .l1_req(l1_req), .wake_req(wake_req));

  // Check order: {tx_l0s_req, rx_l0s_req, l1_req, wake_req}
  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {tx_l0s_req, rx_l0s_req, l1_req, wake_req};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got tx/rx/l1/wake=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; tx_active = 1'b1; rx_active = 1'b1; wake_ack = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);          // one edge samples activity: counts at zero
  endtask

  task automatic t_reset_state;
    do_reset();
    check("R10 reset", 4'b0000);
  endtask

  task automatic t_light_single_dir;
    pm_enable = 2'b01; far_l0s_capable = 1'b1; l0s_idle_limit = 5; l1_idle_limit = 0;
    do_reset();
    tx_active = 1'b0;            // rx stays busy
    step(5); check("R1 tx before limit", 4'b0000);
    step(1); check("R1 tx light entry, rx stays awake", 4'b1000);
  endtask

  task automatic t_restart;
    pm_enable = 2'b01; far_l0s_capable = 1'b1; l0s_idle_limit = 5; l1_idle_limit = 0;
    do_reset();
    rx_active = 1'b0; tx_active = 1'b1;
    step(3); rx_active = 1'b1; step(1); rx_active = 1'b0;
    step(5); check("R11 rx count restarted", 4'b0000);
    step(1); check("R11 rx entry after full limit", 4'b0100);
  endtask

  task automatic t_deep_override;
    pm_enable = 2'b11; far_l0s_capable = 1'b1; l0s_idle_limit = 4; l1_idle_limit = 10;
    do_reset();
    tx_active = 1'b0; rx_active = 1'b0;
    step(5);  check("R1 both light", 4'b1100);
    step(5);  check("R2 deep not yet", 4'b1100);
    step(1);  check("R2 R3 deep replaces light", 4'b0010);
  endtask

  task automatic t_light_not_below;
    pm_enable = 2'b11; far_l0s_capable = 1'b1; l0s_idle_limit = 10; l1_idle_limit = 10;
    do_reset();
    tx_active = 1'b0; rx_active = 1'b0;
    step(10); check("R4 no light at equal limits", 4'b0000);
    step(1);  check("R4 straight to deep", 4'b0010);
  endtask

  task automatic t_partner;
    pm_enable = 2'b01; far_l0s_capable = 1'b0; l0s_idle_limit = 3; l1_idle_limit = 0;
    do_reset();
    tx_active = 1'b0; rx_active = 1'b0;
    step(20); check("R5 no light without partner", 4'b0000);
    far_l0s_capable = 1'b1;
    step(1);  check("R5 light once partner capable", 4'b1100);
    far_l0s_capable = 1'b0;
    step(1);  check("R5 light withdrawn", 4'b0000);
  endtask

  task automatic t_enable_field;
    pm_enable = 2'b10; far_l0s_capable = 1'b1; l0s_idle_limit = 3; l1_idle_limit = 8;
    do_reset();
    tx_active = 1'b0; rx_active = 1'b0;
    step(4); check("R6 10 gives no light", 4'b0000);
    step(5); check("R6 10 gives deep", 4'b0010);
    pm_enable = 2'b00;
    step(1); check("R6 00 withdraws deep", 4'b0000);
    step(5); check("R6 00 stays idle", 4'b0000);
  endtask

  task automatic t_zero_limits;
    pm_enable = 2'b11; far_l0s_capable = 1'b1; l0s_idle_limit = 0; l1_idle_limit = 6;
    do_reset();
    tx_active = 1'b0; rx_active = 1'b0;
    step(6); check("R7 zero light limit", 4'b0000);
    step(1); check("R7 deep still works", 4'b0010);
    l0s_idle_limit = 3; l1_idle_limit = 0;
    do_reset();
    tx_active = 1'b0; rx_active = 1'b0;
    step(4);  check("R7 light with deep off", 4'b1100);
    step(40); check("R7 zero deep limit", 4'b1100);
  endtask

  task automatic t_wake_light;
    pm_enable = 2'b01; far_l0s_capable = 1'b1; l0s_idle_limit = 3; l1_idle_limit = 0;
    do_reset();
    tx_active = 1'b0;
    step(4); check("R1 tx light", 4'b1000);
    tx_active = 1'b1;
    step(1); check("R8 tx traffic wakes", 4'b1001);
    tx_active = 1'b0;
    step(3); check("R9 wake held without ack", 4'b1001);
    wake_ack = 1'b1;
    step(1); check("R9 ack returns active", 4'b0000);
    wake_ack = 1'b0;
    step(3); check("R9 counts restarted", 4'b0000);
    step(1); check("R9 re-entry after full limit", 4'b1000);
  endtask

  task automatic t_wake_deep;
    pm_enable = 2'b10; far_l0s_capable = 1'b0; l0s_idle_limit = 0; l1_idle_limit = 4;
    do_reset();
    tx_active = 1'b0; rx_active = 1'b0;
    wake_ack = 1'b1;                 // an ack with no wake pending does nothing
    step(5); check("R9 stray ack ignored", 4'b0010);
    wake_ack = 1'b0;
    rx_active = 1'b1;
    step(1); check("R8 rx traffic wakes deep", 4'b0011);
    rx_active = 1'b0; wake_ack = 1'b1;
    step(1); check("R9 deep exit", 4'b0000);
    wake_ack = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_light_single_dir();
    t_restart();
    t_deep_override();
    t_light_not_below();
    t_partner();
    t_enable_field();
    t_zero_limits();
    t_wake_light();
    t_wake_deep();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule